// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Controller

This block holds the hazard logic for an in-order integer pipeline with fetch, decode, execute, memory and writeback stages. It compares the source register indices of the instructions in decode and execute with the destination indices held further down the pipe. From that comparison it picks where each operand comes from: the register file, the result latched after execute, or the result latched after memory. One pair of selects feeds the execute-stage operands. A second pair feeds the decode stage, where conditional branches and register-indirect jumps are compared and resolved early.

When forwarding cannot supply a value in time, the controller freezes the program counter and the fetch/decode register and puts a bubble into the decode/execute register. This happens for a load followed by a consumer, and for an early branch whose operand is still being produced. When decode resolves a redirect, the controller discards the single fetched wrong-path instruction. The block is purely combinational. The datapath registers it every cycle.

Top module: `hzd_unit`

## Requirements
- R1: An execute operand select is 1 (take the post-execute latch) when the instruction in memory writes a nonzero rd equal to that operand's index.
- R2: An execute operand select is 2 (take the post-memory latch) when only the instruction in writeback writes a nonzero rd equal to that operand's index.
- R3: When both the memory and the writeback stage match an operand, the select is 1.
- R4: A select is 0 (register file) when the matching rd is x0 or its write enable is low. The value 3 never appears.
- R5: A load in execute whose nonzero rd equals a used decode source raises hold_pc, hold_ifid and bubble_idex for that cycle.
- R6: A source index flagged as unused, or a load with rd x0, causes no stall.
- R7: A conditional branch (rs1, rs2) or a register-indirect jump (rs1) in decode stalls when a writing instruction in execute has a nonzero rd matching a compared source, whether that instruction is an ALU operation or a load.
- R8: A branch whose compared source matches a load in memory stalls. A match against a non-load in memory does not stall, and the decode select is 1.
- R9: The decode operand selects use the same encoding and priority as the execute selects, built from the memory and writeback stage destinations.
- R10: A taken conditional branch, a direct jump or a register-indirect jump in decode raises flush_ifid. A not-taken branch does not.
- R11: flush_ifid is low in any cycle in which the stall outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source index in decode |
| id_rs2 | input | 5 | Second source index in decode |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_is_jal | input | 1 | Decode holds a direct jump |
| id_is_jalr | input | 1 | Decode holds a register-indirect jump |
| id_br_taken | input | 1 | Early comparison outcome of the branch in decode |
| ex_rs1 | input | 5 | First source index in execute |
| ex_rs2 | input | 5 | Second source index in execute |
| ex_rd | input | 5 | Destination index in execute |
| ex_reg_write | input | 1 | Execute instruction writes rd |
| ex_mem_read | input | 1 | Execute instruction is a load |
| mem_rd | input | 5 | Destination index in memory |
| mem_reg_write | input | 1 | Memory instruction writes rd |
| mem_mem_read | input | 1 | Memory instruction is a load |
| wb_rd | input | 5 | Destination index in writeback |
| wb_reg_write | input | 1 | Writeback instruction writes rd |
| fwd_ex_a | output | 2 | Execute first operand source (0 file, 1 post-execute, 2 post-memory) |
| fwd_ex_b | output | 2 | Execute second operand source |
| fwd_id_a | output | 2 | Decode first compare operand source |
| fwd_id_b | output | 2 | Decode second compare operand source |
| hold_pc | output | 1 | Keep the program counter |
| hold_ifid | output | 1 | Keep the fetch/decode register |
| bubble_idex | output | 1 | Load a no-op into decode/execute |
| flush_ifid | output | 1 | Discard the fetched instruction |

## Verification
Random vectors draw every register index from x0..x3, so matches between stages are frequent and often land on several stages at once. This tells the priority rule and the x0 exclusion apart from plain equality. Directed cases set up single hazards in isolation: a load then a consumer, an ALU result then a branch, a load in memory then a branch, and a jump with and without a pending stall. Each case pins down which stall source or forwarding path alone accounts for the outputs. Unused-source cases check that a matching index with its use flag low leaves every output at rest.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    typedef enum logic [1:0] {
        SRC_RF  = 2'd0,
        SRC_MEM = 2'd1,
        SRC_WB  = 2'd2
    } src_sel_e;

    typedef struct packed {
        logic hold;
        logic bubble;
        logic flush;
    } pipe_ctl_t;

    localparam int NUM_OPERANDS = 4;

endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
    import hzd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] rs,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_wen,
    output src_sel_e         sel
);
    logic hit_mem, hit_wb;

    assign hit_mem = mem_wen && (mem_rd != '0) && (mem_rd == rs);
    assign hit_wb  = wb_wen  && (wb_rd  != '0) && (wb_rd  == rs);

    always_comb begin
        if (hit_mem)     sel = SRC_MEM;
        else if (hit_wb) sel = SRC_WB;
        else             sel = SRC_RF;
    end

    always_comb begin
        p_x0_reads_file_r4: assert (rs != '0 || sel == SRC_RF);
        p_sel_in_range_r4: assert (sel != src_sel_e'(2'd3));
    end
endmodule

// File: rtl/hzd_stall_detect.sv
module hzd_stall_detect #(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] id_rs1,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             use1,
    input  logic             use2,
    input  logic             cmp1,
    input  logic             cmp2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_wen,
    input  logic             ex_load,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_wen,
    input  logic             mem_load,
    output logic             load_use,
    output logic             branch_wait
);
    logic ex_live, mem_live_load;
    logic ex_m1, ex_m2, mem_m1, mem_m2;

    assign ex_live       = ex_wen && (ex_rd != '0);
    assign mem_live_load = mem_load && mem_wen && (mem_rd != '0);

    assign ex_m1  = ex_live && (ex_rd == id_rs1);
    assign ex_m2  = ex_live && (ex_rd == id_rs2);
    assign mem_m1 = mem_live_load && (mem_rd == id_rs1);
    assign mem_m2 = mem_live_load && (mem_rd == id_rs2);

    // load in EX feeding any used source
    assign load_use = ex_load && ((ex_m1 && use1) || (ex_m2 && use2));

    // early compare waits for EX producer, or for a load still in MEM
    assign branch_wait = (cmp1 && (ex_m1 || mem_m1)) || (cmp2 && (ex_m2 || mem_m2));

    always_comb begin
        p_unused_no_loaduse_r6: assert (load_use == 1'b0 || use1 || use2);
        p_x0_never_stalls_r6: assert (!(load_use && ex_rd == '0));
    end
endmodule

// File: rtl/hzd_redirect.sv
module hzd_redirect
    import hzd_pkg::*;
(
    input  logic      is_branch,
    input  logic      taken,
    input  logic      is_jal,
    input  logic      is_jalr,
    input  logic      stall,
    output pipe_ctl_t ctl
);
    logic redirect;

    assign redirect   = is_jal || is_jalr || (is_branch && taken);
    assign ctl.hold   = stall;
    assign ctl.bubble = stall;
    assign ctl.flush  = redirect && !stall;

    always_comb begin
        p_nottaken_keeps_r10: assert (!(is_branch && !taken && !is_jal && !is_jalr && ctl.flush));
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] id_rs1,
    input  logic [IDX_W-1:0] id_rs2,
    input  logic             id_use_rs1,
    input  logic             id_use_rs2,
    input  logic             id_is_branch,
    input  logic             id_is_jal,
    input  logic             id_is_jalr,
    input  logic             id_br_taken,
    input  logic [IDX_W-1:0] ex_rs1,
    input  logic [IDX_W-1:0] ex_rs2,
    input  logic [IDX_W-1:0] ex_rd,
    input  logic             ex_reg_write,
    input  logic             ex_mem_read,
    input  logic [IDX_W-1:0] mem_rd,
    input  logic             mem_reg_write,
    input  logic             mem_mem_read,
    input  logic [IDX_W-1:0] wb_rd,
    input  logic             wb_reg_write,
    output logic [1:0]       fwd_ex_a,
    output logic [1:0]       fwd_ex_b,
    output logic [1:0]       fwd_id_a,
    output logic [1:0]       fwd_id_b,
    output logic             hold_pc,
    output logic             hold_ifid,
    output logic             bubble_idex,
    output logic             flush_ifid
);
    logic [IDX_W-1:0] op_rs  [NUM_OPERANDS];
    src_sel_e         op_sel [NUM_OPERANDS];

    assign op_rs[0] = ex_rs1;
    assign op_rs[1] = ex_rs2;
    assign op_rs[2] = id_rs1;
    assign op_rs[3] = id_rs2;

    // one select per operand; EX pair then ID pair
    for (genvar g = 0; g < NUM_OPERANDS; g++) begin : g_pick
        hzd_fwd_pick #(.IDX_W(IDX_W)) u_pick (
            .rs      (op_rs[g]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_reg_write),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_reg_write),
            .sel     (op_sel[g])
        );
    end

    assign fwd_ex_a = op_sel[0];
    assign fwd_ex_b = op_sel[1];
    assign fwd_id_a = op_sel[2];
    assign fwd_id_b = op_sel[3];

    logic cmp1, cmp2, load_use, branch_wait, stall;
    pipe_ctl_t ctl;

    assign cmp1 = (id_is_branch || id_is_jalr) && id_use_rs1;
    assign cmp2 = id_is_branch && id_use_rs2;

    hzd_stall_detect #(.IDX_W(IDX_W)) u_stall (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .use1        (id_use_rs1),
        .use2        (id_use_rs2),
        .cmp1        (cmp1),
        .cmp2        (cmp2),
        .ex_rd       (ex_rd),
        .ex_wen      (ex_reg_write),
        .ex_load     (ex_mem_read),
        .mem_rd      (mem_rd),
        .mem_wen     (mem_reg_write),
        .mem_load    (mem_mem_read),
        .load_use    (load_use),
        .branch_wait (branch_wait)
    );

    assign stall = load_use || branch_wait;

    hzd_redirect u_redir (
        .is_branch (id_is_branch),
        .taken     (id_br_taken),
        .is_jal    (id_is_jal),
        .is_jalr   (id_is_jalr),
        .stall     (stall),
        .ctl       (ctl)
    );

    assign hold_pc     = ctl.hold;
    assign hold_ifid   = ctl.hold;
    assign bubble_idex = ctl.bubble;
    assign flush_ifid  = ctl.flush;

    always_comb begin
        p_no_flush_in_stall_r11: assert (!(flush_ifid && hold_pc));
        p_jal_flushes_r10: assert (!(id_is_jal && !hold_pc) || flush_ifid);
        p_loaduse_holds_r5: assert (!load_use || (hold_ifid && bubble_idex));
        p_mem_prio_r3: assert (!(mem_reg_write && mem_rd != '0 && mem_rd == ex_rs1) || fwd_ex_a == 2'd1);
    end
endmodule

// File: tb/hzd_unit_tb.sv
module hzd_unit_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd;
    logic id_use_rs1, id_use_rs2, id_is_branch, id_is_jal, id_is_jalr, id_br_taken;
    logic ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write;
    logic [1:0] fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b;
    logic hold_pc, hold_ifid, bubble_idex, flush_ifid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    hzd_unit u_dut (.*);

    function automatic logic [1:0] exp_sel(logic [4:0] rs);
        if (mem_reg_write && mem_rd != 0 && mem_rd == rs) return 2'd1;
        if (wb_reg_write && wb_rd != 0 && wb_rd == rs) return 2'd2;
        return 2'd0;
    endfunction

    function automatic logic exp_stall();
        logic lu, bw, c1, c2, e1, e2, m1, m2;
        e1 = ex_reg_write && ex_rd != 0 && ex_rd == id_rs1;
        e2 = ex_reg_write && ex_rd != 0 && ex_rd == id_rs2;
        m1 = mem_mem_read && mem_reg_write && mem_rd != 0 && mem_rd == id_rs1;
        m2 = mem_mem_read && mem_reg_write && mem_rd != 0 && mem_rd == id_rs2;
        c1 = (id_is_branch || id_is_jalr) && id_use_rs1;
        c2 = id_is_branch && id_use_rs2;
        lu = ex_mem_read && ((e1 && id_use_rs1) || (e2 && id_use_rs2));
        bw = (c1 && (e1 || m1)) || (c2 && (e2 || m2));
        return lu || bw;
    endfunction

    function automatic logic exp_flush();
        return (id_is_jal || id_is_jalr || (id_is_branch && id_br_taken)) && !exp_stall();
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic check_all(string ctx);
        chk({ctx, " R1 fwd_ex_a"}, {6'd0, fwd_ex_a}, {6'd0, exp_sel(ex_rs1)});
        chk({ctx, " R2 fwd_ex_b"}, {6'd0, fwd_ex_b}, {6'd0, exp_sel(ex_rs2)});
        chk({ctx, " R9 fwd_id"}, {4'd0, fwd_id_a, fwd_id_b}, {4'd0, exp_sel(id_rs1), exp_sel(id_rs2)});
        chk({ctx, " R5 stall"}, {5'd0, hold_pc, hold_ifid, bubble_idex}, {5'd0, {3{exp_stall()}}});
        chk({ctx, " R10 flush"}, {7'd0, flush_ifid}, {7'd0, exp_flush()});
    endtask

    task automatic clear();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, wb_rd} = '0;
        {id_use_rs1, id_use_rs2, id_is_branch, id_is_jal, id_is_jalr, id_br_taken} = '0;
        {ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write} = '0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        clear();
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk); #1;
        chk("R4 reset idle", {fwd_ex_a, fwd_ex_b, fwd_id_a, fwd_id_b}, 8'd0);
        chk("R11 reset ctl", {4'd0, hold_pc, hold_ifid, bubble_idex, flush_ifid}, 8'd0);

        // R1: ALU result in MEM feeds EX rs1
        @(negedge clk); clear(); ex_rs1 = 5'd7; mem_rd = 5'd7; mem_reg_write = 1; #1;
        chk("R1 mem fwd", {6'd0, fwd_ex_a}, 8'd1);
        // R2: WB only feeds rs2
        @(negedge clk); clear(); ex_rs2 = 5'd9; wb_rd = 5'd9; wb_reg_write = 1; #1;
        chk("R2 wb fwd", {6'd0, fwd_ex_b}, 8'd2);
        // R3: both match
        @(negedge clk); clear(); ex_rs1 = 5'd4; mem_rd = 5'd4; wb_rd = 5'd4;
        mem_reg_write = 1; wb_reg_write = 1; #1;
        chk("R3 priority", {6'd0, fwd_ex_a}, 8'd1);
        // R4: x0 and write disabled
        @(negedge clk); clear(); mem_reg_write = 1; wb_reg_write = 1; #1;
        chk("R4 x0", {6'd0, fwd_ex_a}, 8'd0);
        @(negedge clk); clear(); ex_rs1 = 5'd5; mem_rd = 5'd5; #1;
        chk("R4 no wen", {6'd0, fwd_ex_a}, 8'd0);
        // R5: load-use
        @(negedge clk); clear(); id_rs2 = 5'd3; id_use_rs2 = 1; ex_rd = 5'd3;
        ex_reg_write = 1; ex_mem_read = 1; #1;
        chk("R5 load-use", {5'd0, hold_pc, hold_ifid, bubble_idex}, 8'd7);
        // R6: unused source and x0
        @(negedge clk); id_use_rs2 = 0; #1;
        chk("R6 unused", {5'd0, hold_pc, hold_ifid, bubble_idex}, 8'd0);
        @(negedge clk); clear(); id_use_rs1 = 1; ex_reg_write = 1; ex_mem_read = 1; #1;
        chk("R6 x0 load", {7'd0, hold_pc}, 8'd0);
        // R7: branch after ALU producer in EX; jalr too
        @(negedge clk); clear(); id_is_branch = 1; id_br_taken = 1; id_use_rs1 = 1;
        id_use_rs2 = 1; id_rs1 = 5'd8; ex_rd = 5'd8; ex_reg_write = 1; #1;
        chk("R7 branch ex", {6'd0, hold_pc, flush_ifid}, 8'd2);
        @(negedge clk); clear(); id_is_jalr = 1; id_use_rs1 = 1; id_rs1 = 5'd6;
        ex_rd = 5'd6; ex_reg_write = 1; #1;
        chk("R7 jalr ex R11", {6'd0, hold_pc, flush_ifid}, 8'd2);
        // R8: load in MEM stalls, ALU in MEM forwards
        @(negedge clk); clear(); id_is_branch = 1; id_use_rs1 = 1; id_use_rs2 = 1;
        id_rs2 = 5'd10; mem_rd = 5'd10; mem_reg_write = 1; mem_mem_read = 1; #1;
        chk("R8 load mem", {7'd0, hold_pc}, 8'd1);
        @(negedge clk); mem_mem_read = 0; #1;
        chk("R8 alu mem", {5'd0, hold_pc, fwd_id_b}, 8'd1);
        // R9: ID forwarding from WB
        @(negedge clk); clear(); id_rs1 = 5'd12; wb_rd = 5'd12; wb_reg_write = 1; #1;
        chk("R9 id wb", {6'd0, fwd_id_a}, 8'd2);
        // R10: jal, taken, not taken
        @(negedge clk); clear(); id_is_jal = 1; #1;
        chk("R10 jal", {7'd0, flush_ifid}, 8'd1);
        @(negedge clk); clear(); id_is_branch = 1; id_br_taken = 0; #1;
        chk("R10 not taken", {7'd0, flush_ifid}, 8'd0);
        @(negedge clk); id_br_taken = 1; #1;
        chk("R10 taken", {7'd0, flush_ifid}, 8'd1);

        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            id_rs1 = 5'($urandom_range(3)); id_rs2 = 5'($urandom_range(3));
            ex_rs1 = 5'($urandom_range(3)); ex_rs2 = 5'($urandom_range(3));
            ex_rd = 5'($urandom_range(3)); mem_rd = 5'($urandom_range(3));
            wb_rd = 5'($urandom_range(3));
            {id_use_rs1, id_use_rs2, id_br_taken} = 3'($urandom);
            {ex_reg_write, ex_mem_read, mem_reg_write, mem_mem_read, wb_reg_write} = 5'($urandom);
            case ($urandom_range(3))
                0: {id_is_branch, id_is_jal, id_is_jalr} = 3'b000;
                1: {id_is_branch, id_is_jal, id_is_jalr} = 3'b100;
                2: {id_is_branch, id_is_jal, id_is_jalr} = 3'b010;
                default: {id_is_branch, id_is_jal, id_is_jalr} = 3'b001;
            endcase
            #1;
            check_all("rand");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule